// File: doc/BRIEF.md
# Iterative RC5-style block decryption core

This block undoes a twelve-round, 32-bit-word RC5-style cipher on a 64-bit block. It completes one full inverse round per clock. A ciphertext block is captured into two word registers, A from the upper half and B from the lower half, while the active-low load control is held low. After load is released, the core walks its round index down from 12 to 1. On each step it reads two subkeys from a built-in constant table, subtracts them, rotates right by a data-dependent amount and XORs. One more cycle then strips the initial whitening keys.

When the whitening removal finishes, a one-cycle done pulse marks the output as the recovered plaintext. The output then holds that value until the next load. The core is used by presenting a block, pulsing load low and waiting thirteen clocks.

Top module: `rc5_unround_core`

## Requirements
- R1: The upper 32 bits of `blk_in` are word A and the lower 32 bits are word B. `blk_out` is always {A, B}. While `load_n` is low, both words follow `blk_in` asynchronously, so `blk_out` equals `blk_in` without waiting for a clock edge.
- R2: Subkey table entry k, for k from 0 to 31, holds 32'hB7E15163 + k*32'h9E3779B9 modulo 2^32. The table address is the round index with a parity bit appended as the LSB: parity 0 gives A's subkey and parity 1 gives B's subkey.
- R3: An inverse round at index i first forms B = ((B - S[2i+1]) rotated right by A[4:0]) xor A. It then forms A = ((A - S[2i]) rotated right by the new B[4:0]) xor the new B. Both results are stored at the same clock edge.
- R4: The rotation amount is the low 5 bits of the other word, and every value from 0 to 31 rotates correctly.
- R5: After load is released, the round index starts at 12 and falls by one on each rising edge. Rising edges 1 to 12 apply the rounds for indices 12 down to 1, so `blk_out` after the first edge equals one inverse round at index 12.
- R6: The 13th rising edge after load release subtracts S[1] from B and S[0] from A. No rotation and no XOR are applied on that edge.
- R7: `done` is high for exactly the one cycle following the 13th rising edge and is low at all other times, including during load.
- R8: After the whitening edge, `blk_out` holds its value until the next load.
- R9: For any plaintext P encrypted by the forward cipher using the same table, the core returns P.
- R10: Asserting `load_n` in the middle of a decryption abandons it and restarts from the new block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| load_n | input | 1 | Active-low asynchronous load of the block and restart of the round sequence |
| blk_in | input | 64 | Ciphertext block, A in the upper half |
| blk_out | output | 64 | Current {A, B}; the plaintext once done has pulsed |
| done | output | 1 | One-cycle pulse when decryption completes |

## Verification
A wrong subkey address, rotation direction or order of operations corrupts {A, B} on the very first rising edge. Because the bench compares `blk_out` with a single inverse round after that edge, such a fault is caught one cycle after load. Errors in the counter's start value, step size or end point show up as a final value different from the plaintext, or as a done pulse that arrives early, late or twice. The bench checks these on edge 13 and on the cycles around it. Loss of output hold appears within a few cycles after done. Rotation amounts of 0 and 31 are forced into the first round through directed ciphertexts.

// File: rtl/rc5_unround_core.sv
module rc5_unround_core #(
  parameter int          W        = 32,
  parameter int          ROUNDS   = 12,
  parameter int          KEYS     = 32,
  parameter logic [31:0] KEY_BASE = 32'hB7E15163,
  parameter logic [31:0] KEY_STEP = 32'h9E3779B9
) (
  input  logic           clk,
  input  logic           load_n,
  input  logic [2*W-1:0] blk_in,
  output logic [2*W-1:0] blk_out,
  output logic           done
);
  localparam int AW = $clog2(KEYS);
  localparam int CW = AW - 1;
  localparam int SH = $clog2(W);

  logic [W-1:0] ktab [KEYS];
  for (genvar g = 0; g < KEYS; g++) begin : g_key
    assign ktab[g] = W'(KEY_BASE) + W'(g) * W'(KEY_STEP);
  end

  function automatic logic [W-1:0] ror(input logic [W-1:0] x, input logic [SH-1:0] n);
    logic [W-1:0] t;
    t = x;
    for (int s = 0; s < SH; s++)
      if (n[s]) t = (t >> (1 << s)) | (t << (W - (1 << s)));
    return t;
  endfunction

  logic [W-1:0]  a_q, b_q;
  logic [CW-1:0] rnd_q;
  logic          busy_q, done_q;

  logic [W-1:0] key_a, key_b, a_sub, b_sub, a_rnd, b_rnd;
  logic         last;

  assign key_a = ktab[{rnd_q, 1'b0}];
  assign key_b = ktab[{rnd_q, 1'b1}];
  assign last  = (rnd_q == '0);

  assign b_sub = b_q - key_b;
  assign b_rnd = ror(b_sub, a_q[SH-1:0]) ^ a_q;
  assign a_sub = a_q - key_a;
  assign a_rnd = ror(a_sub, b_rnd[SH-1:0]) ^ b_rnd;

  always_ff @(posedge clk or negedge load_n) begin
    if (!load_n) begin
      a_q    <= blk_in[2*W-1:W];
      b_q    <= blk_in[W-1:0];
      rnd_q  <= CW'(ROUNDS);
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= busy_q && last;
      if (busy_q) begin
        a_q <= last ? a_sub : a_rnd;
        b_q <= last ? b_sub : b_rnd;
        if (last) busy_q <= 1'b0;
        else      rnd_q  <= rnd_q - 1'b1;
      end
    end
  end

  assign blk_out = {a_q, b_q};
  assign done    = done_q;
endmodule

// File: rtl/rc5_unround_chk.sv
module rc5_unround_chk #(
  parameter int W      = 32,
  parameter int CW     = 4,
  parameter int ROUNDS = 12
) (
  input logic           clk,
  input logic           load_n,
  input logic           done,
  input logic [2*W-1:0] blk_out,
  input logic           busy,
  input logic [CW-1:0]  rnd
);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!load_n)
    done |=> !done);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!load_n)
    !busy |=> $stable(blk_out));

  assert_count_down_R5: assert property (@(posedge clk) disable iff (!load_n)
    (busy && rnd != '0) |=> (busy && rnd == $past(rnd) - 1'b1));

  assert_index_range_R5: assert property (@(posedge clk) disable iff (!load_n)
    rnd <= CW'(ROUNDS));

  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!load_n)
    done |-> (!busy && $past(busy) && $past(rnd) == '0));
endmodule

bind rc5_unround_core rc5_unround_chk #(.W(W), .CW(CW), .ROUNDS(ROUNDS)) u_chk (
  .clk(clk), .load_n(load_n), .done(done), .blk_out(blk_out),
  .busy(busy_q), .rnd(rnd_q)
);

// File: tb/rc5_unround_core_tb.sv
module rc5_unround_core_tb;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        load_n = 1'b1;
  logic [63:0] blk_in = '0;
  logic [63:0] blk_out;
  logic        done;
  int          total = 0;
  int          bad = 0;
  bit          finished = 0;

  rc5_unround_core u_dut (.clk(clk), .load_n(load_n), .blk_in(blk_in), .blk_out(blk_out), .done(done));

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [31:0] skey(input int k);
    return 32'hB7E15163 + 32'(k) * 32'h9E3779B9;
  endfunction
  function automatic logic [31:0] rol(input logic [31:0] x, input logic [4:0] n);
    return (x << n) | (x >> (6'd32 - n));
  endfunction
  function automatic logic [31:0] rorb(input logic [31:0] x, input logic [4:0] n);
    return (x >> n) | (x << (6'd32 - n));
  endfunction

  function automatic logic [63:0] enc(input logic [63:0] p);
    logic [31:0] a, b;
    a = p[63:32] + skey(0);
    b = p[31:0] + skey(1);
    for (int i = 1; i <= 12; i++) begin
      a = rol(a ^ b, b[4:0]) + skey(2*i);
      b = rol(b ^ a, a[4:0]) + skey(2*i+1);
    end
    return {a, b};
  endfunction

  function automatic logic [63:0] dec_rounds(input logic [63:0] c, input int from, input int downto_i, input bit whiten);
    logic [31:0] a, b;
    a = c[63:32];
    b = c[31:0];
    for (int i = from; i >= downto_i; i--) begin
      b = rorb(b - skey(2*i+1), a[4:0]) ^ a;
      a = rorb(a - skey(2*i), b[4:0]) ^ b;
    end
    if (whiten) begin
      b = b - skey(1);
      a = a - skey(0);
    end
    return {a, b};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_block(input logic [63:0] ct);
    @(negedge clk);
    blk_in = ct;
    load_n = 1'b0;
    #1;
    check(blk_out == ct, "R1 async load", blk_out, ct);
    check(done == 1'b0, "R7 done low in load", 64'(done), 64'd0);
    @(negedge clk);
    load_n = 1'b1;
  endtask

  task automatic run_block(input logic [63:0] ct, input logic [63:0] pt, input string tag);
    load_block(ct);
    for (int k = 1; k <= 13; k++) begin
      @(negedge clk);
      check(done == (k == 13), "R7 done timing", 64'(done), 64'(k == 13));
      if (k == 1)
        check(blk_out == dec_rounds(ct, 12, 12, 0), "R3 R5 first round", blk_out, dec_rounds(ct, 12, 12, 0));
      if (k == 12)
        check(blk_out == dec_rounds(ct, 12, 1, 0), "R6 before whitening", blk_out, dec_rounds(ct, 12, 1, 0));
    end
    check(blk_out == pt, tag, blk_out, pt);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(blk_out == pt, "R8 hold", blk_out, pt);
      check(done == 1'b0, "R7 single pulse", 64'(done), 64'd0);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] p, c;
    void'($urandom(32'd1234));
    // reset-state check through R1 load
    load_block(64'h0123456789ABCDEF);
    // R2: first round uses table entries 24/25 computed from the formula
    @(negedge clk);
    check(blk_out == dec_rounds(64'h0123456789ABCDEF, 12, 12, 0), "R2 R3 key address", blk_out,
          dec_rounds(64'h0123456789ABCDEF, 12, 12, 0));

    // R9: zero and all-ones plaintexts
    run_block(enc(64'd0), 64'd0, "R9 zero block");
    run_block(enc('1), '1, "R9 ones block");

    // R4: rotation amounts 0 and 31 in the first inverse round
    for (int v = 0; v < 4; v++) begin
      logic [31:0] ah, bl;
      ah = $urandom();
      bl = $urandom();
      ah[4:0] = (v[0]) ? 5'd31 : 5'd0;
      c = {ah, bl};
      p = dec_rounds(c, 12, 1, 1);
      check(enc(p) == c, "R4 model consistency", enc(p), c);
      run_block(c, p, "R4 rotate corner");
    end

    // R9: random plaintexts
    for (int n = 0; n < 40; n++) begin
      p = {$urandom(), $urandom()};
      run_block(enc(p), p, "R9 random block");
    end

    // R10: restart in mid-flight
    p = {$urandom(), $urandom()};
    load_block(enc(64'hDEADBEEFCAFEF00D));
    repeat (5) @(negedge clk);
    run_block(enc(p), p, "R10 restart");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule